// File: doc/BRIEF.md
# Missing-Code Gap Filler

This block sits after a 12-bit successive-approximation converter. Mismatch in that converter's bridge DAC leaves some output codes unreachable, and those gaps repeat at a regular spacing across the code range. The block fills each gap with random redistribution. When a raw code lies just below a missing code, the block reports the missing code in place of that raw code on about half of its occurrences. After this step the code histogram has no empty bins. It does not apply a fixed gain or offset correction.

Configuration supplies the gap spacing as a power-of-two exponent and supplies a phase offset. The set of missing codes is then every code whose distance from the offset is a multiple of the spacing. A 16-bit maximal-length LFSR decides each coin flip. The LFSR steps once for each accepted sample. A bypass control forwards raw codes without change. Results appear one clock after the sample, and the valid flag travels with them.

Top module: `gap_fill_randomizer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_code` both become 0 at that edge.
- R2: `out_valid` at each edge equals `in_valid` at the previous edge. `out_code` carries the result for the sample accepted on that previous edge.
- R3: With k = `cfg_period_log2`, a code m in 0..4095 is missing when (m − `cfg_offset`) mod 2^k is 0. A k of 12 or more leaves only `cfg_offset` itself missing, and a k of 0 makes every code missing.
- R4: A raw code d is a donor when d+1 is missing and d is below 4095, so code 4095 never donates and code 0 never receives. With bypass low, a donor produces d+1 when the random bit is 1 and produces d when the random bit is 0.
- R5: With bypass low, every code that is not a donor comes out unchanged.
- R6: The random bit is bit 0 of a 16-bit state. The state resets to 16'hACE1. On every edge where `in_valid` is 1, bypass or not, the state shifts right one place and is XORed with 16'hB400 when the bit shifted out was 1.
- R7: With `cfg_bypass` high, `out_code` equals the raw sample.
- R8: After a cycle with `in_valid` low, `out_code` keeps its previous value.
- R9: Over 2000 consecutive samples of one donor code, between 40% and 60% of them are replaced by the missing code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bypass | input | 1 | Forward raw codes untouched |
| cfg_period_log2 | input | 4 | Gap spacing exponent k (spacing 2^k) |
| cfg_offset | input | 12 | Phase of the gap pattern |
| in_valid | input | 1 | Raw sample present |
| in_code | input | 12 | Raw converter code |
| out_valid | output | 1 | Result present |
| out_code | output | 12 | Processed code |

## Verification
Full code sweeps run under several spacing and offset settings. A design that tests the wrong neighbour, or that ignores the offset, would move codes that should not move. The boundary settings k=0 and k=12 are swept, as is the top code 4095. A design that wraps 4095 up to 0 would put out 0 for a full-scale input. Idle gaps fall between samples. A design that steps the LFSR on idle cycles, or that skips steps while bypassed, would lose the coin-flip sequence, and the cycle-by-cycle model detects the first wrong bit. A long run on one donor code measures the replacement rate. A random source that is stuck or biased would fall outside the 40–60% window.

// File: rtl/gfr_pkg.sv
package gfr_pkg;
   localparam int GFR_CODE_W   = 12;
   localparam int GFR_LFSR_W   = 16;
   localparam logic [15:0] GFR_LFSR_TAPS = 16'hB400;
   localparam logic [15:0] GFR_LFSR_SEED = 16'hACE1;

   typedef enum logic [1:0] {
      PATH_PASS   = 2'd0,
      PATH_BYPASS = 2'd1,
      PATH_KEEP   = 2'd2,
      PATH_LIFT   = 2'd3
   } gfr_path_e;
endpackage

// File: rtl/gfr_lfsr.sv
module gfr_lfsr #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    TAPS = 16'hB400,
   parameter logic [W-1:0]    SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] state
);
   if (SEED == '0) begin : g_bad_seed
      $error("gfr_lfsr: seed must be nonzero");
   end
   if (W < 3) begin : g_bad_width
      $error("gfr_lfsr: width too small");
   end

   logic [W-1:0] nxt;

   always_comb begin
      nxt = state >> 1;
      if (state[0]) nxt = nxt ^ TAPS;
   end

   always_ff @(posedge clk) begin
      if (rst)      state <= SEED;
      else if (adv) state <= nxt;
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state != '0); // R6
   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(adv)) |-> $stable(state)); // R6
endmodule

// File: rtl/gfr_donor_detect.sv
module gfr_donor_detect #(
   parameter int CODE_W   = 12,
   parameter int PERIOD_W = 4
) (
   input  logic [CODE_W-1:0]   code,
   input  logic [PERIOD_W-1:0] period_log2,
   input  logic [CODE_W-1:0]   offset,
   output logic                is_donor
);
   logic [CODE_W-1:0] mask;
   logic [CODE_W-1:0] target;
   logic [CODE_W-1:0] phase;
   logic              at_top;

   for (genvar i = 0; i < CODE_W; i++) begin : g_mask
      assign mask[i] = (period_log2 > PERIOD_W'(i));
   end

   assign at_top   = &code;
   assign target   = code + CODE_W'(1);
   assign phase    = target - offset;
   assign is_donor = !at_top && ((phase & mask) == '0);
endmodule

// File: rtl/gap_fill_randomizer.sv
module gap_fill_randomizer
   import gfr_pkg::*;
#(
   parameter int          CODE_W    = GFR_CODE_W,
   parameter int          PERIOD_W  = 4,
   parameter int          LFSR_W    = GFR_LFSR_W,
   parameter logic [15:0] LFSR_TAPS = GFR_LFSR_TAPS,
   parameter logic [15:0] LFSR_SEED = GFR_LFSR_SEED
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_bypass,
   input  logic [PERIOD_W-1:0] cfg_period_log2,
   input  logic [CODE_W-1:0]   cfg_offset,
   input  logic                in_valid,
   input  logic [CODE_W-1:0]   in_code,
   output logic                out_valid,
   output logic [CODE_W-1:0]   out_code
);
   localparam int PERIOD_MIN_W = $clog2(CODE_W + 1);

   if (PERIOD_W < PERIOD_MIN_W) begin : g_bad_period_w
      $error("gap_fill_randomizer: PERIOD_W cannot span CODE_W");
   end
   if (LFSR_W != 16) begin : g_bad_lfsr_w
      $error("gap_fill_randomizer: tap set defined for 16 bits only");
   end

   logic [LFSR_W-1:0] rng_state;
   logic              rnd_bit;
   logic              donor;
   gfr_path_e         path;
   logic [CODE_W-1:0] code_nxt;

   gfr_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS[LFSR_W-1:0]),
      .SEED (LFSR_SEED[LFSR_W-1:0])
   ) i_lfsr (
      .clk   (clk),
      .rst   (rst),
      .adv   (in_valid),
      .state (rng_state)
   );

   gfr_donor_detect #(
      .CODE_W   (CODE_W),
      .PERIOD_W (PERIOD_W)
   ) i_detect (
      .code        (in_code),
      .period_log2 (cfg_period_log2),
      .offset      (cfg_offset),
      .is_donor    (donor)
   );

   assign rnd_bit = rng_state[0];

   always_comb begin
      if (cfg_bypass)   path = PATH_BYPASS;
      else if (!donor)  path = PATH_PASS;
      else if (rnd_bit) path = PATH_LIFT;
      else              path = PATH_KEEP;
   end

   always_comb begin
      unique case (path)
         PATH_LIFT: code_nxt = in_code + CODE_W'(1);
         default:   code_nxt = in_code;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_code <= code_nxt;
      end
   end

   AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> out_valid == $past(in_valid)); // R2
   AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid && cfg_bypass)) |-> out_code == $past(in_code)); // R7
   AST_NON_DONOR_PASS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid && !donor)) |-> out_code == $past(in_code)); // R5
   AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid)) |->
         (out_code == $past(in_code) || out_code == $past(in_code) + CODE_W'(1))); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid)) |-> $stable(out_code)); // R8
endmodule

// File: tb/test_gap_fill_randomizer.sv
module test_gap_fill_randomizer;
   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_bypass;
   logic [3:0]  cfg_period_log2;
   logic [11:0] cfg_offset;
   logic        in_valid;
   logic [11:0] in_code;
   logic        out_valid;
   logic [11:0] out_code;

   int checks = 0;
   int errors = 0;
   int m_lfsr = 16'hACE1;
   int m_code = 0;
   bit m_valid = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gap_fill_randomizer i_gap_fill_randomizer (
      .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass),
      .cfg_period_log2(cfg_period_log2), .cfg_offset(cfg_offset),
      .in_valid(in_valid), .in_code(in_code),
      .out_valid(out_valid), .out_code(out_code)
   );

   function automatic bit ref_donor(int d, int k, int off);
      int per;
      if (d >= 4095) return 0;
      per = (k >= 12) ? 4096 : (1 << k);
      return (((d + 1 - off + 4096) % per) == 0);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(bit v, int code);
      string tag;
      @(negedge clk);
      in_valid = v;
      in_code  = code[11:0];
      @(posedge clk);
      tag = "R8";
      if (v) begin
         int rb;
         rb = m_lfsr & 1;
         m_code = code;
         if (cfg_bypass) tag = "R7";
         else if (ref_donor(code, cfg_period_log2, cfg_offset)) begin
            tag = "R3 R4 R6";
            if (rb == 1) m_code = code + 1;
         end else tag = "R5";
         m_lfsr = m_lfsr >> 1;
         if (rb == 1) m_lfsr = m_lfsr ^ 16'hB400;
      end
      m_valid = v;
      #1;
      check(out_valid == m_valid, "R2", out_valid, m_valid);
      check(out_code == m_code[11:0], tag, out_code, m_code);
   endtask

   task automatic sweep(bit idle_gaps);
      for (int c = 0; c < 4096; c++) begin
         step(1'b1, c);
         if (idle_gaps && (c % 7 == 3)) step(1'b0, 12'h5A5);
      end
   endtask

   initial begin
      rst = 1'b1; cfg_bypass = 1'b0; cfg_period_log2 = 4'd6;
      cfg_offset = 12'h020; in_valid = 1'b0; in_code = '0;
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1", out_valid, 0);
      check(out_code == 12'd0, "R1", out_code, 0);
      @(negedge clk); rst = 1'b0;

      sweep(1'b1);                                  // R3 period 64, offset 0x20
      cfg_offset = 12'h003; cfg_period_log2 = 4'd4; sweep(1'b0);
      cfg_period_log2 = 4'd12; cfg_offset = 12'h000; sweep(1'b0); // only code 0 missing
      cfg_period_log2 = 4'd0; sweep(1'b1);          // every code missing, 4095 stays
      cfg_bypass = 1'b1; cfg_period_log2 = 4'd5; sweep(1'b1); // R7
      cfg_bypass = 1'b0;

      begin : r9_rate
         int lifted = 0;
         cfg_period_log2 = 4'd6; cfg_offset = 12'h000;
         for (int i = 0; i < 2000; i++) begin
            step(1'b1, 63);
            if (out_code == 12'd64) lifted++;
         end
         check(lifted >= 800 && lifted <= 1200, "R9", lifted, 1000);
      end
      step(1'b0, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule